// File: doc/BRIEF.md
# Partition Configuration and Write-Engine Arbiter

This block splits four address planes into between one and four partitions. A 3-bit grouping code sets the split. Each code bit cuts the plane sequence at one place. Bit 0 cuts between planes 0 and 1, bit 1 between planes 1 and 2, and bit 2 between planes 2 and 3. For any plane index it returns the number of the partition that holds the plane. Partitions are numbered upward from 0 in plane order.

The block also guards the single shared erase/program engine. A request from any partition takes the engine when it is free. While the engine is busy, every further request is turned away with a reject pulse, and nothing is queued. Reads stay open in every partition except the one that owns the engine. An identify command captures the identifier base of the addressed plane's partition, taken from the grouping in force at that moment. The base is the partition's first plane times 10h, placed in the upper address bits. A parameter chooses the reset grouping.

Top module: `pcfg_arbiter`

## Requirements
- R1: After reset the engine is free, grant_o and reject_o are low, id_base_o is 0, and the grouping code is 001. With the top-parameter option set, the reset code is 100 instead. Under 001, plane 0 is partition 0 and planes 1 to 3 are partition 1.
- R2: part_id_o, for plane_i, equals the count of set code bits below that plane. The code bit at position k cuts between planes k and k+1. So code 000 puts all planes in partition 0, and code 111 puts plane n in partition n.
- R3: A configuration write loads cfg_data_i[10:8] as the new code at the clock edge. Bits 15 to 11 and 7 to 0 have no effect.
- R4: A configuration write is ignored in any cycle in which the engine is busy at the clock edge.
- R5: A request while the engine is free gives a one-cycle grant_o pulse in the next cycle. busy_o then rises, and the owner becomes the partition of plane_i under the code before the edge.
- R6: A request while the engine is busy gives a one-cycle reject_o pulse. The owner and busy_o do not change, and the request is not retried later.
- R7: done_i releases a busy engine at the clock edge. done_i has no effect while the engine is free. A request in the same cycle as the release is rejected.
- R8: rd_ok_o is low exactly when the engine is busy and plane_i lies in the owning partition. Under code 000, every plane is blocked while busy.
- R9: id_cmd_i loads id_base_o with 10h times the first plane of plane_i's partition, giving 00h, 10h, 20h or 30h. The value holds until the next identify command, even across code changes.
- R10: grant_o and reject_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_data_i | input | 16 | Configuration word; code in bits 10:8 |
| plane_i | input | 2 | Plane addressed by the current access |
| req_i | input | 1 | Erase/program request for plane_i's partition |
| done_i | input | 1 | Engine finished its operation |
| id_cmd_i | input | 1 | Identify command written at plane_i |
| part_id_o | output | 2 | Partition number of plane_i |
| grant_o | output | 1 | Request accepted (one-cycle pulse) |
| reject_o | output | 1 | Request refused (one-cycle pulse) |
| busy_o | output | 1 | Engine owned by a partition |
| rd_ok_o | output | 1 | Read of plane_i allowed now |
| id_base_o | output | 6 | Captured identifier base, upper address bits |

## Verification
The hardest cases are the edges on which several things collide. One is a release edge that also carries a request. Another is a release edge that also carries a configuration write. On both edges the engine still counts as busy, so the request is refused and the write is dropped. The stimulus drives done_i, req_i and cfg_we_i in one cycle while the engine is held. It then checks plane partition numbers and read permission to show that the old code survived. A full sweep of all eight codes, with identify commands on every plane, covers each grouping and each base value.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  parameter int unsigned NUM_PLANES = 4;
  parameter int unsigned PLANE_W    = $clog2(NUM_PLANES);
  parameter int unsigned CODE_W     = NUM_PLANES - 1;
  parameter int unsigned CFG_W      = 16;
  parameter int unsigned CODE_LSB   = 8;
  parameter int unsigned BASE_SHIFT = 4;
  parameter int unsigned BASE_W     = PLANE_W + BASE_SHIFT;

  typedef logic [PLANE_W-1:0] plane_t;
  typedef logic [CODE_W-1:0]  code_t;
endpackage

// File: rtl/pcfg_plane_map.sv
module pcfg_plane_map
  import pcfg_pkg::*;
(
  input  code_t  code_i,
  input  plane_t plane_i,
  output plane_t part_o,
  output plane_t first_o
);
  plane_t pid_tab   [NUM_PLANES];
  plane_t first_tab [NUM_PLANES];

  // code bit k separates plane k from plane k+1
  always_comb begin
    pid_tab[0]   = '0;
    first_tab[0] = '0;
    for (int p = 1; p < NUM_PLANES; p++) begin
      pid_tab[p]   = pid_tab[p-1] + plane_t'(code_i[p-1]);
      first_tab[p] = code_i[p-1] ? plane_t'(p) : first_tab[p-1];
    end
  end

  assign part_o  = pid_tab[plane_i];
  assign first_o = first_tab[plane_i];
endmodule

// File: rtl/pcfg_cfg_reg.sv
module pcfg_cfg_reg
  import pcfg_pkg::*;
#(
  parameter code_t RST_CODE = code_t'(1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] data_i,
  input  logic             busy_i,
  output code_t            code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              code_o <= RST_CODE;
    else if (we_i && !busy_i) code_o <= data_i[CODE_LSB +: CODE_W];
  end

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(code_o)); // R4
endmodule

// File: rtl/pcfg_write_arb.sv
module pcfg_write_arb
  import pcfg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   done_i,
  input  plane_t part_i,
  output logic   busy_o,
  output plane_t owner_o,
  output logic   grant_o,
  output logic   reject_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      owner_o  <= '0;
      grant_o  <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      grant_o  <= 1'b0;
      reject_o <= 1'b0;
      if (req_i) begin
        if (busy_o) reject_o <= 1'b1;  // no queue
        else begin
          grant_o <= 1'b1;
          owner_o <= part_i;
        end
      end
      if (!busy_o && req_i)     busy_o <= 1'b1;
      else if (busy_o && done_i) busy_o <= 1'b0;
    end
  end

  AST_REJECT_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_i |=> reject_o && !grant_o); // R6
  AST_OWNER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_i |=> busy_o && $stable(owner_o)); // R6
  AST_GRANT_TAKES_ENGINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> busy_o); // R5
  AST_GRANT_REJECT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && reject_o)); // R10
  AST_DONE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && done_i |=> !busy_o); // R7
endmodule

// File: rtl/pcfg_arbiter.sv
module pcfg_arbiter
  import pcfg_pkg::*;
#(
  parameter bit TOP_PARAM_PART = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic [PLANE_W-1:0] plane_i,
  input  logic              req_i,
  input  logic              done_i,
  input  logic              id_cmd_i,
  output logic [PLANE_W-1:0] part_id_o,
  output logic              grant_o,
  output logic              reject_o,
  output logic              busy_o,
  output logic              rd_ok_o,
  output logic [BASE_W-1:0] id_base_o
);
  localparam code_t RST_CODE = TOP_PARAM_PART ? code_t'(1 << (CODE_W-1)) : code_t'(1);

  code_t  code;
  plane_t part;
  plane_t first;
  plane_t owner;
  logic   busy;

  pcfg_cfg_reg #(.RST_CODE(RST_CODE)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .data_i (cfg_data_i),
    .busy_i (busy),
    .code_o (code)
  );

  pcfg_plane_map u_map (
    .code_i  (code),
    .plane_i (plane_i),
    .part_o  (part),
    .first_o (first)
  );

  pcfg_write_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .done_i   (done_i),
    .part_i   (part),
    .busy_o   (busy),
    .owner_o  (owner),
    .grant_o  (grant_o),
    .reject_o (reject_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       id_base_o <= '0;
    else if (id_cmd_i) id_base_o <= BASE_W'(first) << BASE_SHIFT;
  end

  assign part_id_o = part;
  assign busy_o    = busy;
  assign rd_ok_o   = !(busy && (part == owner));

  AST_ID_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_cmd_i |=> $stable(id_base_o)); // R9
  AST_RD_BLOCK_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ok_o |-> busy_o); // R8
endmodule

// File: tb/pcfg_arbiter_test.sv
module pcfg_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we = 1'b0;
  logic [15:0] cfg_data = '0;
  logic [1:0] plane = '0;
  logic       req = 1'b0;
  logic       done = 1'b0;
  logic       id_cmd = 1'b0;
  logic [1:0] part_id;
  logic       grant, reject, busy, rd_ok;
  logic [5:0] id_base;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  // reference state
  int m_code, m_busy, m_owner, m_grant, m_reject, m_base;

  always #2 clk = ~clk;  // 250 MHz

  pcfg_arbiter uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_data_i(cfg_data),
    .plane_i(plane), .req_i(req), .done_i(done), .id_cmd_i(id_cmd),
    .part_id_o(part_id), .grant_o(grant), .reject_o(reject), .busy_o(busy),
    .rd_ok_o(rd_ok), .id_base_o(id_base)
  );

  function automatic int pid_f(int code, int pl);
    int n = 0;
    for (int i = 0; i < pl; i++) if (code[i]) n++;
    return n;
  endfunction

  function automatic int first_f(int code, int pl);
    int f = 0;
    for (int i = 1; i <= pl; i++) if (code[i-1]) f = i;
    return f;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_code = 1; m_busy = 0; m_owner = 0; m_grant = 0; m_reject = 0; m_base = 0;
    end else begin
      int old_busy, old_code;
      old_busy = m_busy; old_code = m_code;
      m_grant = 0; m_reject = 0;
      if (req) begin
        if (old_busy != 0) m_reject = 1;
        else begin m_grant = 1; m_owner = pid_f(old_code, plane); m_busy = 1; end
      end
      if (done && old_busy != 0) m_busy = 0;
      if (cfg_we && old_busy == 0) m_code = (cfg_data >> 8) & 7;
      if (id_cmd) m_base = first_f(old_code, plane) * 16;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 part_id", part_id, pid_f(m_code, plane));
    chk("R5 grant", grant, m_grant);
    chk("R6 reject", reject, m_reject);
    chk("R7 busy", busy, m_busy);
    chk("R8 rd_ok", rd_ok, !(m_busy != 0 && pid_f(m_code, plane) == m_owner));
    chk("R9 id_base", id_base, m_base);
    if (grant && reject) chk("R10 excl", 1, 0);
  endtask

  task automatic cyc(bit we, logic [15:0] d, int pl, bit rq, bit dn, bit idc);
    @(negedge clk);
    cfg_we = we; cfg_data = d; plane = 2'(pl); req = rq; done = dn; id_cmd = idc;
    #1;
    check_all();
  endtask

  function automatic logic [15:0] cfg_word(int code, logic [7:0] junk);
    return {junk[4:0], 3'(code), ~junk};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, default code 001
    #1;
    chk("R1 grant", grant, 0);
    chk("R1 reject", reject, 0);
    chk("R1 busy", busy, 0);
    chk("R1 id_base", id_base, 0);
    rst_ni = 1'b1;
    for (int p = 0; p < 4; p++) begin
      cyc(0, '0, p, 0, 0, 0);
      chk("R1 default grouping", part_id, (p == 0) ? 0 : 1);
    end
    // R2, R3, R9: every code, reserved bits noisy, identify on each plane
    for (int c = 0; c < 8; c++) begin
      cyc(1, cfg_word(c, 8'(c * 37 + 5)), 0, 0, 0, 0);
      for (int p = 0; p < 4; p++) cyc(0, '0, p, 0, 0, 1);
      cyc(0, '0, 3, 0, 0, 0);
      chk("R3 code 111 four parts", (c == 7) ? part_id : 3, 3);
    end
    // R5, R6, R8: four partitions, plane 2 takes the engine
    cyc(1, cfg_word(7, 8'h3C), 0, 0, 0, 0);
    cyc(0, '0, 2, 1, 0, 0);
    cyc(0, '0, 0, 1, 0, 0);
    for (int p = 0; p < 4; p++) cyc(0, '0, p, 0, 0, 0);
    // R4: write while busy ignored (plane 3 must stay partition 3)
    cyc(1, cfg_word(0, 8'h11), 1, 0, 0, 0);
    cyc(0, '0, 3, 0, 0, 0);
    chk("R4 write ignored", part_id, 3);
    // R7: release, request and config write in the same cycle
    cyc(1, cfg_word(0, 8'h22), 1, 1, 1, 0);
    cyc(0, '0, 3, 0, 0, 0);
    chk("R7 same-cycle write dropped", part_id, 3);
    chk("R6 no retry", busy, 0);
    cyc(0, '0, 0, 0, 1, 0);  // done while idle
    cyc(0, '0, 0, 0, 0, 0);
    // R8: code 101 merges planes 1-2; request on plane 1 blocks plane 2 reads
    cyc(1, cfg_word(5, 8'h99), 0, 0, 0, 0);
    cyc(0, '0, 1, 1, 0, 0);
    for (int p = 0; p < 4; p++) cyc(0, '0, p, 0, 0, 1);
    cyc(0, '0, 2, 0, 0, 0);
    chk("R8 merged plane blocked", rd_ok, 0);
    cyc(0, '0, 0, 0, 1, 0);
    // R8: code 000 blocks every plane while busy
    cyc(1, cfg_word(0, 8'h5A), 0, 0, 0, 0);
    cyc(0, '0, 3, 1, 0, 0);
    for (int p = 0; p < 4; p++) cyc(0, '0, p, 1, 0, 0);
    cyc(0, '0, 0, 0, 1, 0);
    // R5: idle request with done asserted is granted
    cyc(0, '0, 2, 1, 1, 0);
    cyc(0, '0, 2, 0, 0, 0);
    chk("R5 granted with stray done", busy, 1);
    cyc(0, '0, 2, 0, 1, 0);
    cyc(0, '0, 0, 0, 0, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule